// File: doc/BRIEF.md
# Two-Region Flash Erase Range Walker

This block turns one erase request, given as a byte start address and a byte length, into a series of single-block erase commands for a NOR array. The array has two erase regions. The lower region holds small parameter blocks. The upper region starts where the lower one ends and holds large main blocks. Before any command is issued, the walker checks that each end of the range sits on a block boundary of the region that contains that end. It also checks that the range lies inside the array.

For an accepted request, the walker hands one block at a time, in ascending address order, to a downstream command sequencer. Each hand-off is a one-cycle `erase_req` pulse that carries the block address. The walker then waits for `erase_ack`, which comes with a pass/fail flag. The step size is chosen from the current address: it changes from the parameter block size to the main block size when the walk crosses the region boundary. Every request ends with exactly one one-cycle pulse: `done`, `invalid` or `failed`.

Top module: `erase_range_walker`

## Requirements
- R1: After reset `busy`, `erase_req`, `done`, `invalid` and `failed` are all 0.
- R2: A request accepted while idle with `length` = 0 pulses `done` in the cycle after `start`, whatever `start_addr` is, and issues no `erase_req`.
- R3: A request whose start address is at or beyond the array size (8×16 KiB + 31×128 KiB = 0x400000 by default) pulses `invalid` in the cycle after `start` and issues no erase.
- R4: A start address in the lower region (below 0x20000) must be a multiple of 16 KiB (bits 13:0 zero). A start address in the upper region must be a multiple of 128 KiB (bits 16:0 zero). Otherwise the request pulses `invalid` and issues no erase.
- R5: The end address (start + length) is checked against the block size of the region that contains it. An end equal to the region boundary counts as being in the upper region. A misaligned end pulses `invalid` and issues no erase.
- R6: An end address greater than the array size pulses `invalid` and issues no erase.
- R7: For a valid request, exactly one `erase_req` pulse is issued per block in the range, in ascending order. The first address is the start address. Each later address is the previous address plus the block size of the region that contains the previous address.
- R8: `erase_req` lasts one cycle. No further `erase_req` is issued until an `erase_ack` has been seen. The next request follows in the cycle after a passing acknowledge.
- R9: An acknowledge with `erase_fail` = 1 pulses `failed` in the following cycle, and no further `erase_req` is issued for that request.
- R10: After the last passing acknowledge, `done` pulses in the following cycle. Each request produces exactly one of `done`, `invalid` or `failed`, each lasting one cycle.
- R11: `start` is ignored while `busy` is 1. The ongoing walk keeps its addresses and its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| start_addr | input | AW | Byte address of the first block |
| length | input | AW | Byte length of the range |
| busy | output | 1 | A walk is in progress |
| erase_req | output | 1 | One-cycle block erase command |
| erase_addr | output | AW | Block address, valid with `erase_req` |
| erase_ack | input | 1 | Sequencer finished the current block |
| erase_fail | input | 1 | Block erase failed, valid with `erase_ack` |
| done | output | 1 | Request finished successfully (pulse) |
| invalid | output | 1 | Request rejected (pulse) |
| failed | output | 1 | A block erase failed (pulse) |

## Verification
A wrong current address or remaining length becomes visible at the next `erase_req`: the address is off, or the pulse count differs from the expected block list. Either shows up within one acknowledge round trip. A region choice that is wrong at the boundary crossing shows as a 16 KiB step where a 128 KiB step belongs, or the reverse, on the first command past 0x20000. A walk that is stuck or ends early shows as a missing or early `done`, or as an extra command after a failing acknowledge.

// File: rtl/erase_range_walker.sv
module erase_range_walker #(
  parameter int AW      = 23,
  parameter int P_SHIFT = 14,
  parameter int P_COUNT = 8,
  parameter int M_SHIFT = 17,
  parameter int M_COUNT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] length,
  output logic          busy,
  output logic          erase_req,
  output logic [AW-1:0] erase_addr,
  input  logic          erase_ack,
  input  logic          erase_fail,
  output logic          done,
  output logic          invalid,
  output logic          failed
);
  localparam int EW = AW + 1;
  localparam logic [EW-1:0] P_BYTES = EW'(1) << P_SHIFT;
  localparam logic [EW-1:0] M_BYTES = EW'(1) << M_SHIFT;
  localparam logic [EW-1:0] MAIN_BASE = EW'(P_COUNT) << P_SHIFT;
  localparam logic [EW-1:0] ARRAY_END = MAIN_BASE + (EW'(M_COUNT) << M_SHIFT);

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} state_t;
  state_t state;

  logic [EW-1:0] cur, rem;

  function automatic logic off_grid(input logic [EW-1:0] a);
    if (a >= MAIN_BASE) return |a[M_SHIFT-1:0];
    else                return |a[P_SHIFT-1:0];
  endfunction

  wire [EW-1:0] s_ext = {1'b0, start_addr};
  wire [EW-1:0] l_ext = {1'b0, length};
  wire [EW-1:0] e_ext = s_ext + l_ext;
  wire zero_len = (length == '0);
  wire bad_req  = (s_ext >= ARRAY_END) || (e_ext > ARRAY_END) ||
                  off_grid(s_ext) || off_grid(e_ext);
  wire [EW-1:0] step = (cur >= MAIN_BASE) ? M_BYTES : P_BYTES;

  assign busy       = (state != IDLE);
  assign erase_req  = (state == ISSUE);
  assign erase_addr = cur[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      cur     <= '0;
      rem     <= '0;
      done    <= 1'b0;
      invalid <= 1'b0;
      failed  <= 1'b0;
    end else begin
      done    <= 1'b0;
      invalid <= 1'b0;
      failed  <= 1'b0;
      case (state)
        IDLE: if (start) begin
          if (zero_len)     done    <= 1'b1;
          else if (bad_req) invalid <= 1'b1;
          else begin
            cur   <= s_ext;
            rem   <= l_ext;
            state <= ISSUE;
          end
        end
        ISSUE: state <= WAIT;
        WAIT: if (erase_ack) begin
          if (erase_fail) begin
            failed <= 1'b1;
            state  <= IDLE;
          end else if (rem <= step) begin
            done  <= 1'b1;
            state <= IDLE;
          end else begin
            cur   <= cur + step;
            rem   <= rem - step;
            state <= ISSUE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/erase_range_walker_chk.sv
module erase_range_walker_chk #(
  parameter int AW      = 23,
  parameter int P_SHIFT = 14,
  parameter int P_COUNT = 8,
  parameter int M_SHIFT = 17,
  parameter int M_COUNT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] length,
  input logic          busy,
  input logic          erase_req,
  input logic [AW-1:0] erase_addr,
  input logic          erase_ack,
  input logic          done,
  input logic          invalid,
  input logic          failed
);
  localparam longint ARRAY_END = (longint'(P_COUNT) << P_SHIFT) + (longint'(M_COUNT) << M_SHIFT);

  // R2
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && length == '0) |=> done);
  // R7
  req_in_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (longint'(erase_addr) < ARRAY_END));
  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);
  // R8
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> busy);
  // R9
  fail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    failed |-> (!busy && !erase_req));
  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, invalid, failed}));
  // R10
  outcome_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || invalid || failed) |=> !(done || invalid || failed));
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_ack) |=> busy);
endmodule

bind erase_range_walker erase_range_walker_chk #(
  .AW(AW), .P_SHIFT(P_SHIFT), .P_COUNT(P_COUNT), .M_SHIFT(M_SHIFT), .M_COUNT(M_COUNT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .length(length), .busy(busy),
  .erase_req(erase_req), .erase_addr(erase_addr), .erase_ack(erase_ack),
  .done(done), .invalid(invalid), .failed(failed)
);

// File: tb/erase_range_walker_test.sv
module erase_range_walker_test;
  localparam int AW = 23;
  localparam int PB = 16384;
  localparam int MB = 131072;
  localparam int BASE = 8 * PB;
  localparam int TOTAL = BASE + 31 * MB;

  logic clk = 0, rst_n = 0, start = 0, erase_ack = 0, erase_fail = 0;
  logic [AW-1:0] start_addr = '0, length = '0, erase_addr;
  logic busy, erase_req, done, invalid, failed;

  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  erase_range_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
    .busy(busy), .erase_req(erase_req), .erase_addr(erase_addr), .erase_ack(erase_ack),
    .erase_fail(erase_fail), .done(done), .invalid(invalid), .failed(failed));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int blk(input int a);
    return (a >= BASE) ? MB : PB;
  endfunction

  function automatic bit bad(input int s, input int l);
    int e = s + l;
    if (s >= TOTAL || e > TOTAL) return 1;
    if (s % blk(s) != 0) return 1;
    if (e % blk(e) != 0) return 1;
    return 0;
  endfunction

  // outcome codes: 0 done, 1 invalid, 2 failed, 3 none
  task automatic run(input int s, input int l, input int fail_idx, input bit poke, input string tag);
    int exp_a[64];
    int got[64];
    int ne = 0, ng = 0, oc = 3, eo, en;
    if (l == 0) eo = 0;
    else if (bad(s, l)) eo = 1;
    else begin
      for (int a = s; a < s + l; a += blk(a)) begin exp_a[ne] = a; ne++; end
      eo = (fail_idx < ne) ? 2 : 0;
    end
    en = (eo == 1) ? 0 : ((eo == 2) ? fail_idx + 1 : ne);
    @(negedge clk);
    start = 1; start_addr = AW'(s); length = AW'(l);
    @(negedge clk);
    start = 0;
    for (int it = 0; it < 4000; it++) begin
      if (done || invalid || failed) begin
        oc = done ? 0 : (invalid ? 1 : 2);
        break;
      end
      if (erase_req) begin
        if (ng < 64) got[ng] = int'(erase_addr);
        ng++;
        for (int d = 0; d < 1 + int'($urandom_range(2)); d++) begin
          if (poke) begin start = 1; start_addr = '0; length = '0; end
          @(negedge clk);
          start = 0;
          chk(!erase_req, "R8 no req while waiting", 1, 0);
        end
        erase_ack = 1; erase_fail = (ng - 1 == fail_idx);
        @(negedge clk);
        erase_ack = 0; erase_fail = 0;
      end else @(negedge clk);
    end
    chk(oc == eo, {tag, " outcome R10"}, oc, eo);
    chk(ng == en, {tag, " req count R7 R9"}, ng, en);
    for (int i = 0; i < ng && i < en && i < 64; i++)
      chk(got[i] == exp_a[i], {tag, " addr R7"}, got[i], exp_a[i]);
    chk(!busy, {tag, " idle after outcome R10"}, busy, 0);
  endtask

  function automatic int bnd(input int k);
    return (k <= 8) ? k * PB : BASE + (k - 8) * MB;
  endfunction

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !erase_req && !done && !invalid && !failed, "R1 reset state",
        {busy, erase_req, done, invalid, failed}, 0);

    run(0, 0, 99, 0, "R2 zero len");
    run(TOTAL + 4096, 0, 99, 0, "R2 zero len off array");
    run(TOTAL, PB, 99, 0, "R3 start beyond");
    run('h2000, PB, 99, 0, "R4 param misaligned");
    run('h30000, MB, 99, 0, "R4 main misaligned");
    run('h1C000, 'h8000, 99, 0, "R5 end misaligned in main");
    run(0, 'h6000, 99, 0, "R5 end misaligned in param");
    run('h3E0000, 'h40000, 99, 0, "R6 end beyond");
    run(0, TOTAL, 99, 0, "R7 whole array");
    run('h18000, 'h28000, 99, 0, "R7 crossing");
    run(TOTAL - MB, MB, 99, 0, "R7 last block");
    run(0, BASE, 0, 0, "R9 fail first");
    run('h1C000, 'h24000, 1, 0, "R9 fail at crossing");
    run('h40000, 4 * MB, 99, 1, "R11 start while busy");

    for (int n = 0; n < 60; n++) begin
      int si = int'($urandom_range(38));
      int ei = si + 1 + int'($urandom_range(38 - si));
      int s = bnd(si), e = bnd(ei);
      int fi = ($urandom_range(3) == 0) ? int'($urandom_range(ei - si)) : 99;
      case ($urandom_range(5))
        0: s += 4096;
        1: e -= 4096;
        default: ;
      endcase
      run(s, e - s, fi, $urandom_range(4) == 0, "random R7 R8 R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule